// File: doc/BRIEF.md
# Order-Preserving Dual-Clock Frame FIFO with Debt Tracking

This block carries a stream of fixed-width frames from a write clock domain to a read clock domain. It never refuses a transaction. When the small physical store is full, a write is not rejected. The frame loses its payload, but its place in the stream is kept by a write-side debt counter. That debt is later paid back by pushing placeholder entries that carry a lost flag. When the store is empty, a read still completes. It returns a lost frame and raises a read-side debt. That debt is settled by discarding the next real entries the reader pulls.

Because of these two counters, every write produces exactly one frame at the read side, in write order. Only the payload of frames that did not fit is forgotten. The read domain also publishes a virtual occupancy value, whose counter width can be much wider than the physical address width. It is formed from three terms: the physical fill level, the read debt, and a copy of the write debt that a toggle request/acknowledge handshake refreshes continuously.

Top module: `lossless_order_fifo`

## Requirements
- R1: After both resets release, `rd_vld` is 0 and `rd_occ` is 0.
- R2: The physical store holds at most 2^ADDR_W-1 entries. Starting from an empty, settled state, a burst of writes keeps the first 2^ADDR_W-1 frames with their data, and every further frame comes out lost.
- R3: A write made while the store is full is never discarded. It raises the write debt by one, and the frame count seen in `rd_occ` includes it.
- R4: While the store is not full and the write debt is nonzero, the write side pushes a lost entry (data zero) and lowers the debt. A write arriving in that cycle replaces the lowered unit, so lost markers stay ahead of every newer frame.
- R5: A write made with zero debt and a store that is not full is stored as a normal entry with its data intact.
- R6: A read made while the store is empty raises the read debt and returns a frame with `rd_lost`=1 and `rd_data`=0.
- R7: A read made while the store holds entries and the read debt is nonzero removes one entry, returns it with `rd_lost`=1 and data zero, and lowers the read debt.
- R8: A read made with zero read debt removes one entry and returns its data and its stored lost flag, so frames leave in write order.
- R9: `rd_occ` equals the physical fill level, minus the read debt, plus the read domain's copy of the write debt, all modulo 2^OCC_W. Example: one read from empty with no write debt gives 2^OCC_W-1.
- R10: Each read request produces exactly one response: `rd_vld` is high during the single `rd_clk` cycle after the request edge, and low otherwise.
- R11: The captured write debt does not change while a handshake request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous active-low reset |
| wr_en | input | 1 | Frame present on `wr_data` this cycle |
| wr_data | input | DATA_W | Frame payload |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain asynchronous active-low reset |
| rd_req | input | 1 | Read one frame this cycle |
| rd_vld | output | 1 | Response to the previous cycle's request |
| rd_lost | output | 1 | Response frame has no payload |
| rd_data | output | DATA_W | Response payload, zero when lost |
| rd_occ | output | OCC_W | Virtual occupancy in the read domain |

## Verification
A read response is registered, so it is sampled at the falling `rd_clk` edge that follows the request's rising edge. The next falling edge must show `rd_vld` low again. Effects that cross domains take longer. A freed slot is seen by the writer after two synchronizer stages, and a new write debt reaches `rd_occ` only after a full handshake round trip. The bench therefore spaces reads ten read cycles apart, and it compares `rd_occ` only after a settle window of sixty read cycles with no traffic. Expected frames come from a bench queue model: a frame is lost exactly when the model holds 2^ADDR_W-1 or more pending frames at the moment it is written.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;

  typedef enum logic [1:0] {
    RK_IDLE  = 2'd0,
    RK_EMPTY = 2'd1,
    RK_DEBT  = 2'd2,
    RK_DATA  = 2'd3
  } rd_kind_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) begin
      b[i] = ^(g >> i);
    end
    return b;
  endfunction

endpackage

// File: rtl/ofifo_rst_sync.sv
module ofifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n   <= stage_q;
    end
  end
endmodule

// File: rtl/ofifo_sync.sv
module ofifo_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ofifo_wr_ctrl.sv
module ofifo_wr_ctrl
  import ofifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int OCC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   rgray_s,
  input  logic              ack_s,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W:0]   mem_wdata,
  output logic [ADDR_W:0]   wgray,
  output logic              req_tgl,
  output logic [OCC_W-1:0]  cap_debt
);
  localparam int PW  = ADDR_W + 1;
  localparam int CAP = (1 << ADDR_W) - 1;

  logic [PW-1:0]    wbin, wbin_nxt, rbin, level;
  logic [OCC_W-1:0] debt, debt_nxt, cap_nxt;
  logic             full, has_debt, push, pend, req_nxt;

  assign rbin     = PW'(gray2bin(32'(rgray_s)));
  assign level    = wbin - rbin;
  assign full     = (level == PW'(CAP));
  assign has_debt = (debt != '0);
  assign push     = !full && (wr_en || has_debt);
  assign pend     = (req_tgl != ack_s);

  always_comb begin
    wbin_nxt = push ? wbin + PW'(1) : wbin;
    debt_nxt = debt;
    if (full) begin
      debt_nxt = debt + OCC_W'(wr_en);
    end else if (has_debt && !wr_en) begin
      debt_nxt = debt - OCC_W'(1);
    end
    cap_nxt = pend ? cap_debt : debt;
    req_nxt = pend ? req_tgl : ~req_tgl;
  end

  assign mem_we    = push;
  assign mem_addr  = wbin[ADDR_W-1:0];
  assign mem_wdata = has_debt ? {1'b1, {DATA_W{1'b0}}} : {1'b0, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      debt     <= '0;
      cap_debt <= '0;
      req_tgl  <= 1'b0;
    end else begin
      if (push) begin
        wbin  <= wbin_nxt;
        wgray <= PW'(bin2gray(32'(wbin_nxt)));
      end
      debt <= debt_nxt;
      if (!pend) begin
        cap_debt <= cap_nxt;
      end
      req_tgl <= req_nxt;
    end
  end

  assert_level_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(CAP));
  assert_full_write_debt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> (debt == $past(debt) + OCC_W'(1)));
  assert_debt_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && has_debt && !wr_en) |=> (debt == $past(debt) - OCC_W'(1)));
  assert_cap_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> $stable(cap_debt));
endmodule

// File: rtl/ofifo_rd_ctrl.sv
module ofifo_rd_ctrl
  import ofifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int OCC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic              req_s,
  input  logic [OCC_W-1:0]  cap_debt,
  input  logic [DATA_W:0]   mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W:0]   rgray,
  output logic              ack_tgl,
  output logic              rd_vld,
  output logic              rd_lost,
  output logic [DATA_W-1:0] rd_data,
  output logic [OCC_W-1:0]  rd_occ
);
  localparam int PW = ADDR_W + 1;

  rd_kind_e         kind;
  logic [PW-1:0]    rbin, rbin_nxt, wbin, count;
  logic [OCC_W-1:0] rdebt, rdebt_nxt, wdebt_s;
  logic             empty, pop, lost_nxt, take;
  logic [DATA_W-1:0] data_nxt;

  assign wbin  = PW'(gray2bin(32'(wgray_s)));
  assign count = wbin - rbin;
  assign empty = (count == '0);
  assign take  = (req_s != ack_tgl);

  always_comb begin
    kind = RK_IDLE;
    if (rd_req) begin
      if (empty)              kind = RK_EMPTY;
      else if (rdebt != '0)   kind = RK_DEBT;
      else                    kind = RK_DATA;
    end
    pop       = (kind == RK_DEBT) || (kind == RK_DATA);
    rbin_nxt  = pop ? rbin + PW'(1) : rbin;
    rdebt_nxt = rdebt;
    case (kind)
      RK_EMPTY: rdebt_nxt = rdebt + OCC_W'(1);
      RK_DEBT:  rdebt_nxt = rdebt - OCC_W'(1);
      default:  rdebt_nxt = rdebt;
    endcase
    lost_nxt = (kind == RK_DATA) ? mem_rdata[DATA_W] : 1'b1;
    data_nxt = (kind == RK_DATA && !mem_rdata[DATA_W]) ? mem_rdata[DATA_W-1:0] : '0;
  end

  assign mem_addr = rbin[ADDR_W-1:0];
  assign rd_occ   = OCC_W'(count) - rdebt + wdebt_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rdebt   <= '0;
      wdebt_s <= '0;
      ack_tgl <= 1'b0;
      rd_vld  <= 1'b0;
      rd_lost <= 1'b0;
      rd_data <= '0;
    end else begin
      if (pop) begin
        rbin  <= rbin_nxt;
        rgray <= PW'(bin2gray(32'(rbin_nxt)));
      end
      rdebt <= rdebt_nxt;
      if (take) begin
        wdebt_s <= cap_debt;
        ack_tgl <= req_s;
      end
      rd_vld <= rd_req;
      if (rd_req) begin
        rd_lost <= lost_nxt;
        rd_data <= data_nxt;
      end
    end
  end

  assert_empty_read_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> (rd_vld && rd_lost && rd_data == '0));
  assert_debt_read_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !empty && rdebt != '0) |=> (rd_lost && rdebt == $past(rdebt) - OCC_W'(1)));
  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld);
  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_vld);
endmodule

// File: rtl/lossless_order_fifo.sv
module lossless_order_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int OCC_W  = 16
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_req,
  output logic              rd_vld,
  output logic              rd_lost,
  output logic [DATA_W-1:0] rd_data,
  output logic [OCC_W-1:0]  rd_occ
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic              w_rst_n, r_rst_n;
  logic              mem_we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W:0]   wdata, rdata;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic              req_tgl, req_s, ack_tgl, ack_s;
  logic [OCC_W-1:0]  cap_debt;
  logic [DATA_W:0]   mem [DEPTH];

  ofifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(wr_rst_n), .rst_n(w_rst_n));
  ofifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rd_rst_n), .rst_n(r_rst_n));

  ofifo_sync #(.WIDTH(PW + 1)) u_to_wr (
    .clk(wr_clk), .rst_n(w_rst_n),
    .d({rgray, ack_tgl}), .q({rgray_s, ack_s}));

  ofifo_sync #(.WIDTH(PW + 1)) u_to_rd (
    .clk(rd_clk), .rst_n(r_rst_n),
    .d({wgray, req_tgl}), .q({wgray_s, req_s}));

  always_ff @(posedge wr_clk) begin
    if (mem_we) begin
      mem[waddr] <= wdata;
    end
  end
  assign rdata = mem[raddr];

  ofifo_wr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OCC_W(OCC_W)) u_wr (
    .clk(wr_clk), .rst_n(w_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rgray_s(rgray_s), .ack_s(ack_s), .mem_we(mem_we), .mem_addr(waddr),
    .mem_wdata(wdata), .wgray(wgray), .req_tgl(req_tgl), .cap_debt(cap_debt));

  ofifo_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OCC_W(OCC_W)) u_rd (
    .clk(rd_clk), .rst_n(r_rst_n), .rd_req(rd_req), .wgray_s(wgray_s),
    .req_s(req_s), .cap_debt(cap_debt), .mem_rdata(rdata), .mem_addr(raddr),
    .rgray(rgray), .ack_tgl(ack_tgl), .rd_vld(rd_vld), .rd_lost(rd_lost),
    .rd_data(rd_data), .rd_occ(rd_occ));
endmodule

// File: tb/lossless_order_fifo_test.sv
`timescale 1ns/1ps
module lossless_order_fifo_test;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int OCC_W  = 16;
  localparam int CAP    = (1 << ADDR_W) - 1;

  logic              wr_clk = 1'b0, rd_clk = 1'b0;
  logic              wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_req = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_vld, rd_lost;
  logic [DATA_W-1:0] rd_data;
  logic [OCC_W-1:0]  rd_occ;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  int exp_d[$];
  bit exp_l[$];

  lossless_order_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OCC_W(OCC_W)) uut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req), .rd_vld(rd_vld),
    .rd_lost(rd_lost), .rd_data(rd_data), .rd_occ(rd_occ));

  always #5 wr_clk = ~wr_clk;
  always #6 rd_clk = ~rd_clk;

  function automatic bit frame_lost(input int pending);
    return pending >= CAP;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic settle();
    repeat (60) @(negedge rd_clk);
  endtask

  task automatic write_burst(input int k, input int base, input bit randomize_data);
    for (int i = 0; i < k; i++) begin
      int d;
      d = randomize_data ? int'($urandom_range(0, 255)) : ((base + i) & 8'hFF);
      exp_l.push_back(frame_lost(exp_d.size()));
      exp_d.push_back(d);
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = DATA_W'(d);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic read_one(output bit lost, output int data);
    @(negedge rd_clk);
    rd_req = 1'b1;
    @(negedge rd_clk);
    rd_req = 1'b0;
    check("R10 response strobe", int'(rd_vld), 1);
    lost = rd_lost;
    data = int'(rd_data);
  endtask

  task automatic read_check();
    bit lost, el;
    int data, ed;
    el = exp_l.pop_front();
    ed = exp_d.pop_front();
    read_one(lost, data);
    if (el) begin
      check("R2/R4 lost flag", int'(lost), 1);
      check("R4 lost data zero", data, 0);
    end else begin
      check("R8 stored flag", int'(lost), 0);
      check("R5 data", data, ed);
    end
    repeat (10) @(negedge rd_clk);
  endtask

  initial begin
    #2000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    bit lost;
    int data;
    void'($urandom(32'd1234));
    #50;
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    repeat (8) @(negedge rd_clk);
    check("R1 rd_vld after reset", int'(rd_vld), 0);
    check("R1 rd_occ after reset", int'(rd_occ), 0);

    // R6: read from empty store
    read_one(lost, data);
    check("R6 lost on empty", int'(lost), 1);
    check("R6 data zero", data, 0);
    @(negedge rd_clk);
    check("R10 strobe one cycle", int'(rd_vld), 0);
    settle();
    check("R9 occ with read debt", int'(rd_occ), (1 << OCC_W) - 1);

    // R7: read debt discards the next real entry
    write_burst(2, 8'h11, 1'b0);
    exp_d.delete();
    exp_l.delete();
    settle();
    check("R9 occ two minus one", int'(rd_occ), 1);
    read_one(lost, data);
    check("R7 debt read lost", int'(lost), 1);
    check("R7 debt read data zero", data, 0);
    repeat (10) @(negedge rd_clk);
    read_one(lost, data);
    check("R8 next entry valid", int'(lost), 0);
    check("R8 next entry data", data, 8'h12);
    settle();
    check("R9 occ zero after debt", int'(rd_occ), 0);

    // R2/R3/R4: overfill the store
    write_burst(CAP + 5, 8'h40, 1'b0);
    settle();
    check("R3 occ counts overflow", int'(rd_occ), CAP + 5);
    write_burst(3, 8'h90, 1'b0);
    settle();
    check("R3 occ after more writes", int'(rd_occ), CAP + 8);
    while (exp_d.size() > 0) read_check();
    settle();
    check("R9 occ drained", int'(rd_occ), 0);

    // mixed random bursts and reads
    for (int round = 0; round < 14; round++) begin
      int k, j;
      k = int'($urandom_range(0, 22));
      write_burst(k, 0, 1'b1);
      settle();
      check("R9 occ after burst", int'(rd_occ), exp_d.size());
      j = int'($urandom_range(0, exp_d.size()));
      for (int r = 0; r < j; r++) read_check();
      settle();
      check("R9 occ after reads", int'(rd_occ), exp_d.size());
    end
    while (exp_d.size() > 0) read_check();
    finish_up();
  end
endmodule